// File: doc/BRIEF.md
# Composite Video Level Composer

This block turns one colour channel's pixel code into the composite level code that a current-steering DAC needs in order to produce standard composite video. Every clock it takes an 8-bit channel code, active-low blank and sync flags, a setup-pedestal enable and a code-width select. It registers a 9-bit level in DAC LSB units. A 3-bit class code comes out in the same cycle and names the level region that applies. A display pipe uses three copies, one each for red, green and blue.

The level is the sum of three parts. The first is a sync pedestal of 110 units, removed while sync is low. The second is a setup pedestal of 21 units, added only during active video when setup is enabled. The third is the channel code, which counts only during active video. In narrow (6-bit) colour mode the two low code bits are cleared before the sum. Sync does not take priority over blank or data. A true sync level (zero output) therefore occurs only while blank is also low.

Top module: `video_level_composer`

## Requirements
- R1: While rst_n is low, level_o is 0 and class_o is 0 (sync class).
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge (one cycle of latency).
- R3: With blank_n_i low and sync_n_i low, level_o is 0 and class_o is 0, whatever the code, setup or width inputs.
- R4: With blank_n_i low and sync_n_i high, level_o is 110 and class_o is 1 (blank), whatever the code, setup or width inputs.
- R5: With blank_n_i high, level_o equals the effective code, plus 21 when setup_en_i is 1, plus 110 when sync_n_i is 1.
- R6: When setup_en_i is 0 and blank_n_i is high, a zero code gives the same level as blank (110). When setup_en_i is 1, black sits 21 units above blank (131).
- R7: When wide_code_i is 0, bits 1:0 of the channel code are treated as zero. When it is 1, all 8 bits count.
- R8: With blank_n_i high, class_o is 2 (black) for an effective code of 0, 4 (white) for the mode's full-scale code (FFh wide, FCh narrow), and 3 (data) otherwise.
- R9: Peak white in wide mode is 386 with setup and sync, 365 without setup, and 276 with setup and sync low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_code_i | input | 8 | Channel code for this pixel |
| blank_n_i | input | 1 | Active-low blank |
| sync_n_i | input | 1 | Active-low sync (removes the 110-unit pedestal) |
| setup_en_i | input | 1 | 1 adds the 21-unit setup pedestal during active video |
| wide_code_i | input | 1 | 1 = 8-bit codes, 0 = 6-bit codes (low two bits cleared) |
| level_o | output | 9 | Composite level in DAC LSB units |
| class_o | output | 3 | Level class: 0 sync, 1 blank, 2 black, 3 data, 4 white |

## Verification
The case hardest to reach is the one where several controls disagree. Examples are sync low during active video with setup on, where the level must be data plus setup with no sync pedestal, and a narrow-mode code of FCh-FFh, which must be classed white. Random codes seldom land on those values. The stimulus therefore walks a directed grid over every combination of blank, sync, setup and width, using the codes 00h, 01h, 03h, FCh, FEh and FFh. A long random run follows, and a behavioural model checks every cycle of it.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  typedef enum logic [2:0] {
    LV_SYNC  = 3'd0,
    LV_BLANK = 3'd1,
    LV_BLACK = 3'd2,
    LV_DATA  = 3'd3,
    LV_WHITE = 3'd4
  } lvl_class_e;

  // Sum of sync pedestal, gated setup pedestal and gated data term.
  function automatic int unsigned compose_level(
    input int unsigned code,
    input bit          blank_n,
    input bit          sync_n,
    input bit          setup_en,
    input int unsigned sync_units,
    input int unsigned setup_units
  );
    int unsigned acc;
    acc = sync_n ? sync_units : 0;
    if (blank_n) begin
      acc = acc + code;
      if (setup_en) acc = acc + setup_units;
    end
    return acc;
  endfunction

endpackage

// File: rtl/vlc_code_cond.sv
module vlc_code_cond #(
  parameter int CODE_W    = 8,
  parameter int DROP_LSBS = 2
) (
  input  logic [CODE_W-1:0] raw_i,
  input  logic              wide_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] full_o
);
  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    if (b < DROP_LSBS) begin : g_low
      assign code_o[b] = raw_i[b] & wide_i;
      assign full_o[b] = wide_i;
    end else begin : g_high
      assign code_o[b] = raw_i[b];
      assign full_o[b] = 1'b1;
    end
  end
endmodule

// File: rtl/vlc_level_sum.sv
module vlc_level_sum #(
  parameter int CODE_W      = 8,
  parameter int SYNC_UNITS  = 110,
  parameter int SETUP_UNITS = 21,
  parameter int OUT_W       = 9
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              blank_n_i,
  input  logic              sync_n_i,
  input  logic              setup_en_i,
  output logic [OUT_W-1:0]  level_o
);
  import vlc_pkg::*;

  int unsigned sum;

  always_comb begin
    sum = compose_level(32'(code_i), blank_n_i, sync_n_i, setup_en_i,
                        SYNC_UNITS, SETUP_UNITS);
    level_o = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/vlc_classifier.sv
module vlc_classifier #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [CODE_W-1:0]  full_i,
  input  logic               blank_n_i,
  input  logic               sync_n_i,
  output vlc_pkg::lvl_class_e class_o
);
  import vlc_pkg::*;

  always_comb begin
    if (!blank_n_i)           class_o = sync_n_i ? LV_BLANK : LV_SYNC;
    else if (code_i == '0)    class_o = LV_BLACK;
    else if (code_i == full_i) class_o = LV_WHITE;
    else                      class_o = LV_DATA;
  end
endmodule

// File: rtl/video_level_composer.sv
module video_level_composer #(
  parameter int CODE_W      = 8,
  parameter int DROP_LSBS   = 2,
  parameter int SYNC_UNITS  = 110,
  parameter int SETUP_UNITS = 21,
  parameter int OUT_W       = $clog2((1 << CODE_W) + SYNC_UNITS + SETUP_UNITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] chan_code_i,
  input  logic              blank_n_i,
  input  logic              sync_n_i,
  input  logic              setup_en_i,
  input  logic              wide_code_i,
  output logic [OUT_W-1:0]  level_o,
  output logic [2:0]        class_o
);
  import vlc_pkg::*;

  // Named internal events for the checker.
  logic [CODE_W-1:0] cond_code;
  logic [CODE_W-1:0] full_code;
  logic [OUT_W-1:0]  level_d;
  lvl_class_e        class_d;
  lvl_class_e        class_q;

  vlc_code_cond #(.CODE_W(CODE_W), .DROP_LSBS(DROP_LSBS)) u_cond (
    .raw_i  (chan_code_i),
    .wide_i (wide_code_i),
    .code_o (cond_code),
    .full_o (full_code)
  );

  vlc_level_sum #(
    .CODE_W(CODE_W), .SYNC_UNITS(SYNC_UNITS),
    .SETUP_UNITS(SETUP_UNITS), .OUT_W(OUT_W)
  ) u_sum (
    .code_i     (cond_code),
    .blank_n_i  (blank_n_i),
    .sync_n_i   (sync_n_i),
    .setup_en_i (setup_en_i),
    .level_o    (level_d)
  );

  vlc_classifier #(.CODE_W(CODE_W)) u_cls (
    .code_i    (cond_code),
    .full_i    (full_code),
    .blank_n_i (blank_n_i),
    .sync_n_i  (sync_n_i),
    .class_o   (class_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_o <= '0;
      class_q <= LV_SYNC;
    end else begin
      level_o <= level_d;
      class_q <= class_d;
    end
  end

  assign class_o = class_q;
endmodule

// File: rtl/vlc_checker.sv
module vlc_checker #(
  parameter int CODE_W      = 8,
  parameter int SYNC_UNITS  = 110,
  parameter int SETUP_UNITS = 21,
  parameter int OUT_W       = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] chan_code_i,
  input logic              blank_n_i,
  input logic              sync_n_i,
  input logic              setup_en_i,
  input logic              wide_code_i,
  input logic [CODE_W-1:0] cond_code,
  input logic [OUT_W-1:0]  level_o,
  input logic [2:0]        class_o
);
  localparam logic [OUT_W-1:0] BLANK_LVL = OUT_W'(SYNC_UNITS);
  localparam logic [OUT_W-1:0] BLACK_LVL = OUT_W'(SYNC_UNITS + SETUP_UNITS);
  localparam logic [OUT_W-1:0] WHITE_LVL =
    OUT_W'((1 << CODE_W) - 1 + SYNC_UNITS + SETUP_UNITS);
  localparam logic [1:0] PED_LSBS = 2'(SYNC_UNITS % 4);

  p_sync_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n_i && !sync_n_i) |=> (level_o == '0 && class_o == 3'd0));

  p_blank_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n_i && sync_n_i) |=> (level_o == BLANK_LVL && class_o == 3'd1));

  p_black_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n_i && sync_n_i && setup_en_i && cond_code == '0)
      |=> (level_o == BLACK_LVL && class_o == 3'd2));

  p_narrow_lsbs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n_i && sync_n_i && !setup_en_i && !wide_code_i)
      |=> (level_o[1:0] == PED_LSBS));

  p_peak_white_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n_i && sync_n_i && setup_en_i && wide_code_i && chan_code_i == '1)
      |=> (level_o == WHITE_LVL && class_o == 3'd4));

  p_class_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    class_o <= 3'd4);
endmodule

bind video_level_composer vlc_checker #(
  .CODE_W(CODE_W), .SYNC_UNITS(SYNC_UNITS),
  .SETUP_UNITS(SETUP_UNITS), .OUT_W(OUT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_code_i (chan_code_i),
  .blank_n_i   (blank_n_i),
  .sync_n_i    (sync_n_i),
  .setup_en_i  (setup_en_i),
  .wide_code_i (wide_code_i),
  .cond_code   (cond_code),
  .level_o     (level_o),
  .class_o     (class_o)
);

// File: tb/video_level_composer_tb.sv
module video_level_composer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] chan_code_i = '0;
  logic       blank_n_i = 1'b0;
  logic       sync_n_i = 1'b0;
  logic       setup_en_i = 1'b0;
  logic       wide_code_i = 1'b1;
  logic [8:0] level_o;
  logic [2:0] class_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int exp_lvl_q[$];
  int exp_cls_q[$];
  string exp_tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  video_level_composer dut_i (
    .clk(clk), .rst_n(rst_n), .chan_code_i(chan_code_i),
    .blank_n_i(blank_n_i), .sync_n_i(sync_n_i), .setup_en_i(setup_en_i),
    .wide_code_i(wide_code_i), .level_o(level_o), .class_o(class_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: compute expected outputs from the requirements.
  task automatic model(input int code, input bit bl, input bit sy,
                       input bit su, input bit wd);
    int eff, lvl, cls, full;
    string tag;
    eff  = wd ? code : code - (code % 4);
    full = wd ? 255 : 252;
    if (!bl) begin
      lvl = sy ? 110 : 0;
      cls = sy ? 1 : 0;
      tag = sy ? "R4" : "R3";
    end else begin
      lvl = eff + (su ? 21 : 0) + (sy ? 110 : 0);
      cls = (eff == 0) ? 2 : ((eff == full) ? 4 : 3);
      if (wd && code == 255) tag = "R9";
      else if (!wd) tag = "R7";
      else if (eff == 0) tag = "R6";
      else tag = "R5";
    end
    exp_lvl_q.push_back(lvl);
    exp_cls_q.push_back(cls);
    exp_tag_q.push_back(tag);
  endtask

  task automatic compare_pending();
    int l, c;
    string t;
    if (exp_lvl_q.size() == 0) return;
    l = exp_lvl_q.pop_front();
    c = exp_cls_q.pop_front();
    t = exp_tag_q.pop_front();
    check({t, " level"}, int'(level_o), l);
    check("R8 class", int'(class_o), c);
  endtask

  task automatic apply(input int code, input bit bl, input bit sy,
                       input bit su, input bit wd, input bit lat_chk);
    int prev;
    @(negedge clk);
    compare_pending();
    prev = int'(level_o);
    chan_code_i = 8'(code);
    blank_n_i   = bl;
    sync_n_i    = sy;
    setup_en_i  = su;
    wide_code_i = wd;
    model(code, bl, sy, su, wd);
    if (lat_chk) begin
      #1;
      check("R2 latency", int'(level_o), prev);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int codes[6] = '{0, 1, 3, 252, 254, 255};
    // R1: reset state, with busy inputs
    chan_code_i = 8'hFF; blank_n_i = 1; sync_n_i = 1; setup_en_i = 1;
    repeat (3) @(negedge clk);
    check("R1 level", int'(level_o), 0);
    check("R1 class", int'(class_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: change inputs, output must hold until the next edge
    apply(200, 1, 1, 1, 1, 1);
    apply(10, 0, 1, 0, 1, 1);
    // R9 explicit peaks
    apply(255, 1, 1, 1, 1, 0);
    apply(255, 1, 1, 0, 1, 0);
    apply(255, 1, 0, 1, 1, 0);
    // Directed grid over every control combination
    for (int k = 0; k < 6; k++)
      for (int m = 0; m < 16; m++)
        apply(codes[k], m[0], m[1], m[2], m[3], 0);
    // R6: black equals blank without setup
    apply(0, 1, 1, 0, 1, 0);
    apply(0, 0, 1, 0, 1, 0);
    // Random run
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom;
      apply(r & 255, r[8] | r[9], r[10] | r[11], r[12], r[13], n % 97 == 0);
    end
    @(negedge clk);
    compare_pending();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule